// File: doc/BRIEF.md
# ECC SRAM Controller with Read-Modify-Write

This controller stands between a simple 64-bit bus slave port and a single-port synchronous SRAM. Each 64-bit word is kept in the array together with 8 check bits of a single-error-correcting, double-error-detecting Hamming code. A full aligned doubleword write encodes the data and stores it at once. A byte, halfword or word write cannot supply a whole codeword, so the controller reads the containing word, corrects it, merges the new bytes into it, re-encodes it and writes it back.

The number of wait states depends on what the bus did in the cycle before. A narrow write that directly follows a completed write to the same doubleword skips the array read: the word that was just written is kept in a register and used as the merge base. A narrow write that directly follows a read waits one extra turnaround cycle. Reads return the corrected word. A single-bit error produces a correctable-error pulse. A double-bit error produces an uncorrectable-error pulse and an error response. In both cases the failing word address is given. Because the array powers up with random contents, software must write every location with a full doubleword before it trusts any read or narrow write.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: An aligned doubleword write (size code 3, address bits [2:0] zero) completes with ready high in its first cycle (0 wait states). Back-to-back doubleword writes complete one per cycle. A later read of that word returns the written data.
- R2: An aligned read shows ready low for exactly one cycle and then high. In the cycle with ready high, rdata carries the whole 64-bit word at address bits [ADDR_W-1:3].
- R3: A narrow write (size code 0 = byte, 1 = halfword, 2 = word) that is not in the situations of R4 or R5 takes 1 wait state. It changes only the byte lanes from address bits [2:0] up to that offset plus the access width minus one, using the same lanes of wdata.
- R4: A narrow write whose request cycle directly follows the completion cycle of a read takes 2 wait states.
- R5: A narrow write whose request cycle directly follows the completion cycle of a successful write to the same doubleword takes 0 wait states. The merge uses the word just written.
- R6: When the stored word has one flipped bit, a read returns the corrected word with err low, and ce_pulse is high in the completion cycle with err_word set to the word address. A narrow write to such a word also pulses ce_pulse and writes back the corrected, merged word, so the next read is clean. ce_pulse and ue_pulse are never high together.
- R7: When the stored word has two flipped bits, a read or narrow write completes with err high, ue_pulse high and err_word set to the word address. The narrow write stores nothing, so the word stays uncorrectable.
- R8: A misaligned access (halfword with address bit 0 set, word with address bits [1:0] nonzero, doubleword with address bits [2:0] nonzero) completes at once with err high and does not touch the array.
- R9: Reset is synchronous and active low. While rst_n is low, ready, err and both pulses are low and the array is not accessed. An access that had not completed when reset was applied leaves every location unchanged, and completed writes survive reset.
- R10: A doubleword write to a location that holds an uncorrectable word makes the next read of it clean, with no error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| addr | input | ADDR_W | Byte address |
| wdata | input | 64 | Write data on its byte lanes |
| ready | output | 1 | Access completes in this cycle |
| err | output | 1 | Error response with ready |
| rdata | output | 64 | Corrected read word, valid with ready on reads |
| ce_pulse | output | 1 | Correctable error seen in this cycle |
| ue_pulse | output | 1 | Uncorrectable error seen in this cycle |
| err_word | output | ADDR_W-3 | Word address belonging to an error pulse |

## Verification
Stored bit errors cannot be reached from the ports, because every write goes through the encoder. The bench therefore flips one or two bits of a stored codeword directly in the array while the bus is idle. Flipping any single bit or any pair of bits yields a single or double error whatever the check-bit layout is. Both reads and narrow writes are then sent at those words. A read that follows shows whether the write-back happened. Aborting a merge with reset needs a reset in the middle of an access: the bench starts a narrow write, asserts reset in its merge cycle, and reads the word back afterwards.

// File: rtl/ecc_sram_pkg.sv
// Package: shared constants, enums and the SECDED (72,64) code functions.
// Assumes 64-bit data words; codeword bit 0 holds overall parity, bits
// at power-of-two positions hold Hamming checks, the rest hold data.
package ecc_sram_pkg;
    localparam int DATA_W = 64;
    localparam int CODE_W = 72;
    localparam int LANES  = DATA_W / 8;
    localparam int HAM_W  = 7;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DWORD = 2'd3} size_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RDAT, ST_TURN, ST_RMW} ctrl_st_e;
    typedef enum logic [1:0] {LK_NONE, LK_READ, LK_WRITE} last_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              single;
        logic              dbl;
    } dec_t;

    // True for codeword positions reserved for check bits (0 and powers of two).
    function automatic logic is_chk_pos(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Build a codeword from a data word.
    function automatic logic [CODE_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] cw;
        int k;
        logic x;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_chk_pos(p)) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < HAM_W; b++) begin
            x = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> b) & 1) == 1 && !is_chk_pos(p)) x = x ^ cw[p];
            end
            cw[1 << b] = x;
        end
        cw[0] = ^cw[CODE_W-1:1];
        return cw;
    endfunction

    // Check a codeword, correct one flipped bit, flag two.
    function automatic dec_t ecc_decode(input logic [CODE_W-1:0] cw);
        logic [HAM_W-1:0] syn;
        logic par;
        logic [CODE_W-1:0] c;
        int k;
        dec_t r;
        syn = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (cw[p]) syn = syn ^ HAM_W'(p);
        end
        par = ^cw;
        c = cw;
        r.single = 1'b0;
        r.dbl    = 1'b0;
        if (par) begin
            if (syn == '0) begin
                r.single = 1'b1;
            end else if (int'(syn) < CODE_W) begin
                c[syn]   = ~c[syn];
                r.single = 1'b1;
            end else begin
                r.dbl = 1'b1;
            end
        end else if (syn != '0) begin
            r.dbl = 1'b1;
        end
        r.data = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_chk_pos(p)) begin
                r.data[k] = c[p];
                k++;
            end
        end
        return r;
    endfunction

    // Byte lanes touched by an access of the given size at the given offset.
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [2:0] off);
        logic [LANES-1:0] m;
        int nb;
        nb = 1 << sz;
        for (int b = 0; b < LANES; b++) m[b] = (b >= int'(off)) && (b < int'(off) + nb);
        return m;
    endfunction

    // True when the offset is a multiple of the access width.
    function automatic logic is_aligned(input logic [1:0] sz, input logic [2:0] off);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return off[0] == 1'b0;
            SZ_WORD: return off[1:0] == 2'b00;
            default: return off == 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/ecc_sram_enc.sv
// Encoder: combinational SECDED check-bit generation for one data word.
// Assumes the codeword layout defined in ecc_sram_pkg.
module ecc_sram_enc
    import ecc_sram_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    // Encode the word to be stored.
    always_comb code_o = ecc_encode(data_i);
endmodule

// File: rtl/ecc_sram_dec.sv
// Decoder: combinational SECDED check and single-bit correction.
// Assumes the codeword layout defined in ecc_sram_pkg.
module ecc_sram_dec
    import ecc_sram_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    dec_t res;

    // Decode the word read from the array.
    always_comb begin
        res      = ecc_decode(code_i);
        data_o   = res.data;
        single_o = res.single;
        double_o = res.dbl;
    end
endmodule

// File: rtl/ecc_sram_merge.sv
// Byte merge: takes each lane from the new data where the mask is set,
// else from the base word. Purely combinational.
module ecc_sram_merge #(
    parameter int LANE_N = 8
) (
    input  logic [LANE_N*8-1:0] base_i,
    input  logic [LANE_N*8-1:0] new_i,
    input  logic [LANE_N-1:0]   lane_i,
    output logic [LANE_N*8-1:0] merged_o
);
    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        // Select the source of one byte lane.
        assign merged_o[g*8 +: 8] = lane_i[g] ? new_i[g*8 +: 8] : base_i[g*8 +: 8];
    end
endmodule

// File: rtl/ecc_sram_array.sv
// Single-port synchronous RAM: one read or one write per cycle, read data
// registered and valid the cycle after the read. No reset of contents.
module ecc_sram_array #(
    parameter int AW = 9,
    parameter int W  = 72
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Perform the single access of this cycle.
    always_ff @(posedge clk) begin
        if (en && we)  mem[addr] <= wdata;
        if (en && !we) rdata     <= mem[addr];
    end
endmodule

// File: rtl/ecc_sram_ctrl.sv
// ECC SRAM controller: bus slave in front of a single-port array holding
// SECDED codewords. Full writes store directly, narrow writes do a
// read-modify-write, and wait states depend on the previous cycle.
// Assumes the master holds req and all request fields stable until ready.
module ecc_sram_ctrl
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    output logic              ready,
    output logic              err,
    output logic [63:0]       rdata,
    output logic              ce_pulse,
    output logic              ue_pulse,
    output logic [ADDR_W-4:0] err_word
);
    localparam int WORD_AW = ADDR_W - 3;

    ctrl_st_e st, st_nxt;
    last_e    last_kind, done_kind;
    logic [WORD_AW-1:0] last_word;
    logic [DATA_W-1:0]  fwd_word;

    logic [WORD_AW-1:0] word;
    logic [2:0]         off;
    logic               full, ok_align, fwd_hit, st_idle;
    logic [LANES-1:0]   lanes;

    logic               arr_en, arr_we;
    logic [CODE_W-1:0]  arr_wcode, arr_rcode;
    logic [DATA_W-1:0]  dec_data, merge_base, merged, store_data;
    logic               dec_single, dec_double;

    // Decode the request fields.
    always_comb begin
        word     = addr[ADDR_W-1:3];
        off      = addr[2:0];
        full     = (size == SZ_DWORD);
        ok_align = is_aligned(size, off);
        lanes    = lane_mask(size, off);
        st_idle  = (st == ST_IDLE);
        fwd_hit  = (last_kind == LK_WRITE) && (last_word == word);
    end

    // Choose the merge base: the forwarded word when idle, else the read word.
    always_comb merge_base = st_idle ? fwd_word : dec_data;

    ecc_sram_merge #(.LANE_N(LANES)) u_merge (
        .base_i   (merge_base),
        .new_i    (wdata),
        .lane_i   (lanes),
        .merged_o (merged)
    );

    // Pick the data word that a write stores.
    always_comb store_data = full ? wdata : merged;

    ecc_sram_enc u_enc (
        .data_i (store_data),
        .code_o (arr_wcode)
    );

    ecc_sram_array #(.AW(WORD_AW), .W(CODE_W)) u_arr (
        .clk   (clk),
        .en    (arr_en),
        .we    (arr_we),
        .addr  (word),
        .wdata (arr_wcode),
        .rdata (arr_rcode)
    );

    ecc_sram_dec u_dec (
        .code_i   (arr_rcode),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    // Sequence the access: response, array control and next state.
    always_comb begin
        ready     = 1'b0;
        err       = 1'b0;
        ce_pulse  = 1'b0;
        ue_pulse  = 1'b0;
        arr_en    = 1'b0;
        arr_we    = 1'b0;
        done_kind = LK_NONE;
        st_nxt    = st;
        case (st)
            ST_IDLE: begin
                if (req) begin
                    if (!ok_align) begin
                        ready = 1'b1;
                        err   = 1'b1;
                    end else if (!we) begin
                        arr_en = 1'b1;
                        st_nxt = ST_RDAT;
                    end else if (full || fwd_hit) begin
                        arr_en    = 1'b1;
                        arr_we    = 1'b1;
                        ready     = 1'b1;
                        done_kind = LK_WRITE;
                    end else if (last_kind == LK_READ) begin
                        st_nxt = ST_TURN;
                    end else begin
                        arr_en = 1'b1;
                        st_nxt = ST_RMW;
                    end
                end
            end
            ST_TURN: begin
                arr_en = 1'b1;
                st_nxt = ST_RMW;
            end
            ST_RDAT: begin
                ready     = 1'b1;
                err       = dec_double;
                ce_pulse  = dec_single;
                ue_pulse  = dec_double;
                done_kind = LK_READ;
                st_nxt    = ST_IDLE;
            end
            default: begin
                ready    = 1'b1;
                ce_pulse = dec_single;
                ue_pulse = dec_double;
                st_nxt   = ST_IDLE;
                if (dec_double) begin
                    err = 1'b1;
                end else begin
                    arr_en    = 1'b1;
                    arr_we    = 1'b1;
                    done_kind = LK_WRITE;
                end
            end
        endcase
        if (!rst_n) begin
            ready     = 1'b0;
            err       = 1'b0;
            ce_pulse  = 1'b0;
            ue_pulse  = 1'b0;
            arr_en    = 1'b0;
            arr_we    = 1'b0;
            done_kind = LK_NONE;
            st_nxt    = ST_IDLE;
        end
    end

    // Present the corrected word and the word address of any error.
    always_comb begin
        rdata    = dec_data;
        err_word = word;
    end

    // Hold the state and the record of the previous cycle's completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            last_kind <= LK_NONE;
            last_word <= '0;
            fwd_word  <= '0;
        end else begin
            st        <= st_nxt;
            last_kind <= done_kind;
            last_word <= word;
            if (done_kind == LK_WRITE) fwd_word <= store_data;
        end
    end
endmodule

// File: rtl/ecc_sram_chk.sv
// Checker: protocol and safety properties of ecc_sram_ctrl, attached by bind.
module ecc_sram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       we,
    input logic [1:0] size,
    input logic [2:0] addr_lo,
    input logic       ready,
    input logic       err,
    input logic       ce_pulse,
    input logic       ue_pulse,
    input logic       arr_en,
    input logic       arr_we,
    input logic       st_idle
);
    logic misal;
    // Recompute misalignment from the size and offset.
    always_comb misal = (size == 2'd1 && addr_lo[0]) ||
                        (size == 2'd2 && addr_lo[1:0] != 2'b00) ||
                        (size == 2'd3 && addr_lo != 3'b000);

    AST_FULL_WR_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && req && we && size == 2'd3 && addr_lo == 3'b000) |-> (ready && arr_en && arr_we))
        else $error("full write waited"); // R1
    AST_RD_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && req && !we && !misal) |-> (!ready && arr_en && !arr_we))
        else $error("read did not wait"); // R2
    AST_RD_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && req && !we && !misal) |=> ready)
        else $error("read did not complete"); // R2
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_pulse && ue_pulse))
        else $error("both pulses"); // R6
    AST_UE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse |-> (!(arr_en && arr_we) && err && ready))
        else $error("write-back after uncorrectable"); // R7
    AST_MISALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && req && misal) |-> (ready && err && !arr_en))
        else $error("misaligned accepted"); // R8

    // Check that no array access happens while reset is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_NO_ACCESS: assert (!arr_en) else $error("access in reset"); // R9
        end
    end
endmodule

bind ecc_sram_ctrl ecc_sram_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .size     (size),
    .addr_lo  (addr[2:0]),
    .ready    (ready),
    .err      (err),
    .ce_pulse (ce_pulse),
    .ue_pulse (ue_pulse),
    .arr_en   (arr_en),
    .arr_we   (arr_we),
    .st_idle  (st_idle)
);

// File: tb/test_ecc_sram_ctrl.sv
// Bench: behavioural reference model of contents, error state and wait
// states; every transaction cycle is compared against it.
module test_ecc_sram_ctrl;
    localparam int AW    = 12;
    localparam int WORDS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic we = 1'b0;
    logic [1:0] size = 2'd0;
    logic [AW-1:0] addr = '0;
    logic [63:0] wdata = '0;
    logic ready, err, ce_pulse, ue_pulse;
    logic [63:0] rdata;
    logic [AW-4:0] err_word;

    always #4 clk = ~clk;

    ecc_sram_ctrl #(.ADDR_W(AW)) i_ecc_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .ready(ready), .err(err), .rdata(rdata),
        .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .err_word(err_word)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] m_mem [WORDS];
    int m_bad [WORDS];
    int m_last = 0;
    int m_last_word = -1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101);
    endfunction

    // One bus transaction, compared cycle by cycle with the model.
    task automatic xfer(input bit w, input logic [1:0] sz, input int baddr,
                        input logic [63:0] d, input string tag);
        int wd, off, nb, waits, exp_waits, nxt_last;
        bit exp_err, exp_ce, exp_ue, chk_rd;
        logic [63:0] exp_data;
        wd = baddr >> 3; off = baddr & 7; nb = 1 << sz;
        exp_err = 0; exp_ce = 0; exp_ue = 0; chk_rd = 0; exp_data = '0; nxt_last = 0;
        if ((off % nb) != 0) begin
            exp_waits = 0; exp_err = 1;
        end else if (!w) begin
            exp_waits = 1; exp_ce = (m_bad[wd] == 1); exp_ue = (m_bad[wd] == 2);
            exp_err = exp_ue; chk_rd = !exp_ue; exp_data = m_mem[wd]; nxt_last = 1;
        end else if (sz == 2'd3) begin
            exp_waits = 0; m_mem[wd] = d; m_bad[wd] = 0; nxt_last = 2;
        end else begin
            if (m_last == 2 && m_last_word == wd) exp_waits = 0;
            else if (m_last == 1) exp_waits = 2;
            else exp_waits = 1;
            if (m_bad[wd] == 2) begin
                exp_ue = 1; exp_err = 1;
            end else begin
                exp_ce = (m_bad[wd] == 1);
                for (int b = 0; b < 8; b++)
                    if (b >= off && b < off + nb) m_mem[wd][b*8 +: 8] = d[b*8 +: 8];
                m_bad[wd] = 0; nxt_last = 2;
            end
        end
        @(negedge clk);
        req = 1'b1; we = w; size = sz; addr = AW'(baddr); wdata = d;
        #2;
        waits = 0;
        while (!ready && waits < 6) begin
            check(!ce_pulse && !ue_pulse, tag, "pulse during wait", {62'd0, ce_pulse, ue_pulse}, 64'd0);
            waits++;
            @(negedge clk);
            #2;
        end
        check(waits == exp_waits, tag, "wait states", 64'(waits), 64'(exp_waits));
        check(err == exp_err, tag, "err", 64'(err), 64'(exp_err));
        check(ce_pulse == exp_ce && ue_pulse == exp_ue, tag, "ce/ue",
              {62'd0, ce_pulse, ue_pulse}, {62'd0, exp_ce, exp_ue});
        if (exp_ce || exp_ue)
            check(int'(err_word) == wd, tag, "err_word", 64'(err_word), 64'(wd));
        if (chk_rd) check(rdata == exp_data, tag, "rdata", rdata, exp_data);
        m_last = nxt_last; m_last_word = wd;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req = 1'b0;
        end
        m_last = 0;
    endtask

    // Flip one or two stored bits of a word while the bus is idle.
    task automatic inject(input int wd, input int nbits);
        logic [71:0] mask;
        mask = 72'd1 << 5;
        if (nbits == 2) mask = mask | (72'd1 << 40);
        @(negedge clk);
        i_ecc_sram_ctrl.u_arr.mem[wd] = i_ecc_sram_ctrl.u_arr.mem[wd] ^ mask;
        m_bad[wd] = nbits;
    endtask

    bit done = 0;

    initial begin
        for (int i = 0; i < WORDS; i++) begin m_mem[i] = '0; m_bad[i] = 0; end
        repeat (3) @(negedge clk);
        #2;
        check(!ready && !err && !ce_pulse && !ue_pulse, "R9", "outputs in reset",
              {60'd0, ready, err, ce_pulse, ue_pulse}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        // R1 / R10: initialise every word with back-to-back doubleword writes
        for (int i = 0; i < WORDS; i++) xfer(1, 2'd3, i * 8, pat(i), "R1");
        idle(2);
        // R2: reads, back to back
        for (int i = 0; i < 4; i++) xfer(0, 2'd3, i * 8, 64'd0, "R2");
        // R4: narrow write right after a read
        xfer(1, 2'd0, 5 * 8 + 3, 64'hFFEE_DDCC_BBAA_9988, "R4");
        idle(1);
        // R3 then R5: narrow writes, forwarded back to back
        xfer(1, 2'd1, 6 * 8 + 2, 64'h1111_2222_3333_4444, "R3");
        xfer(1, 2'd2, 6 * 8 + 4, 64'h5555_6666_7777_8888, "R5");
        xfer(1, 2'd0, 6 * 8 + 7, 64'h9900_0000_0000_0000, "R5");
        xfer(1, 2'd3, 7 * 8, 64'hCAFE_F00D_DEAD_BEEF, "R1");
        xfer(1, 2'd0, 7 * 8 + 1, 64'h0000_0000_0000_5A00, "R5");
        xfer(1, 2'd1, 8 * 8 + 6, 64'hABCD_0000_0000_0000, "R3");
        idle(1);
        xfer(0, 2'd3, 5 * 8, 64'd0, "R3");
        xfer(0, 2'd3, 6 * 8, 64'd0, "R5");
        xfer(0, 2'd3, 7 * 8, 64'd0, "R5");
        idle(1);
        // R8: misaligned sizes, then word unchanged
        xfer(1, 2'd1, 9 * 8 + 1, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        xfer(1, 2'd2, 9 * 8 + 2, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        xfer(0, 2'd3, 9 * 8 + 4, 64'd0, "R8");
        idle(1);
        xfer(0, 2'd3, 9 * 8, 64'd0, "R8");
        idle(1);
        // R6: single-bit error on reads and on a merge
        inject(10, 1);
        xfer(0, 2'd3, 10 * 8, 64'd0, "R6");
        xfer(0, 2'd3, 10 * 8, 64'd0, "R6");
        idle(1);
        xfer(1, 2'd0, 10 * 8, 64'h0000_0000_0000_0077, "R6");
        idle(1);
        xfer(0, 2'd3, 10 * 8, 64'd0, "R6");
        idle(1);
        // R7: double-bit error aborts the write-back
        inject(11, 2);
        xfer(0, 2'd3, 11 * 8, 64'd0, "R7");
        idle(1);
        xfer(1, 2'd2, 11 * 8 + 4, 64'h7777_7777_0000_0000, "R7");
        idle(1);
        xfer(0, 2'd3, 11 * 8, 64'd0, "R7");
        idle(1);
        // R10: a full write cleans the uncorrectable word
        xfer(1, 2'd3, 11 * 8, 64'h0BAD_0BAD_0BAD_0BAD, "R10");
        idle(1);
        xfer(0, 2'd3, 11 * 8, 64'd0, "R10");
        idle(1);
        // R9: reset in the merge cycle of a narrow write
        @(negedge clk);
        req = 1'b1; we = 1'b1; size = 2'd0; addr = AW'(12 * 8 + 2); wdata = '1;
        #2 check(!ready, "R9", "first cycle of aborted write", 64'(ready), 64'd0);
        @(negedge clk); rst_n = 1'b0;
        #2 check(!ready && !ce_pulse && !ue_pulse, "R9", "outputs in reset",
                 {61'd0, ready, ce_pulse, ue_pulse}, 64'd0);
        @(negedge clk); req = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_last = 0;
        // R9 / R1: every word matches the model after reset
        for (int i = 0; i < WORDS; i++) xfer(0, 2'd3, i * 8, 64'd0, "R9");
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule